// File: doc/BRIEF.md
# Programmable Interval Pulse Timer

This block counts timebase enables (one per period of a 32.768 kHz base) and drives an active-low pulse pin at a selectable interval of 0.1 s, 1 s, 10 s, 30 s or 60 s. Each pulse lasts exactly one timebase period. A sticky interval flag records that a period has elapsed. The same counter serves both the repeating mode and the single-shot mode. A stop bit freezes the count without losing it. A separate reset bit restarts it from zero. An output-disable bit holds the pin high. A special function code routes an external busy indication to the pin in place of the timer pulse.

The 0.1 s setting cannot be met by a uniform integer count, so successive short intervals use slightly different lengths. A group of five short intervals always spans exactly half a second of timebase enables. All durations are expressed through the parameter `HALF_SEC_TICKS`, the number of timebase enables in 0.5 s. Its default is 16384, which gives four short intervals of 3277 enables followed by one of 3276.

A narrow write port loads either the function register (`wr_sel_i`=0) or the control register (`wr_sel_i`=1). The internal sequencer has four states. ST_IDLE is entered for reserved codes and the busy code. ST_HOLD means counting is stopped. ST_RUN means counting is active. ST_DONE is reached after a single-shot pulse. Its transitions are as follows:
- Restart goes to ST_IDLE, ST_HOLD or ST_RUN, depending on the code and the stop bit.
- ST_HOLD goes to ST_RUN when the stop bit is cleared.
- ST_RUN goes to ST_HOLD when the stop bit is set.
- ST_RUN goes to ST_DONE on a pulse when single-shot mode is selected.

Top module: `interval_pulse_timer`

## Requirements
- R1: After reset the pin is high, the flag is low, the function code is 0000, and the timer is stopped (control bit 2 = 1), so no pulse occurs until a control write clears bit 2.
- R2: A function write (`wr_sel_i`=0) loads the code; bits [2:0] select the period (000 = 0.1 s, 001 = 1 s, 010 = 10 s, 011 = 30 s, 100 = 60 s), and bit 3 = 1 selects single-shot. Codes 101 and 110 in bits [2:0] produce no pulse.
- R3: Measured from a restart, the 1 s, 10 s, 30 s and 60 s codes fire on timebase enable number 2H, 20H, 60H and 120H respectively, where H = `HALF_SEC_TICKS`. The pin goes low in the cycle that follows the enable which completes the period.
- R4: In 0.1 s mode the intervals repeat in groups of five. If H mod 5 = r, the first r intervals of each group last floor(H/5)+1 enables and the others last floor(H/5). Each group therefore sums to exactly H.
- R5: Each pulse holds the pin low for exactly one timebase period: from the firing enable until the next enable.
- R6: In repeat mode (bit 3 = 0) pulses recur every period. In single-shot mode exactly one pulse occurs one period after the restart, and none afterwards.
- R7: Control bit 2 = 1 stops counting with the count held. Clearing it resumes counting, so that the interval counted before the stop plus the interval counted after it equal one full period.
- R8: Control bit 1 = 1 restarts the count from zero. Any function write also restarts it.
- R9: While control bit 0 = 1 the pin stays high, although periods still elapse and still set the flag.
- R10: The flag is set when a period elapses and stays set until a control write with bit 3 = 1 clears it.
- R11: With function bits [2:0] = 111 the pin shows `busy_i` (low while busy is high), still subject to the output disable. No timer pulse is produced in this mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timebase enable, one cycle per base period |
| busy_i | input | 1 | External busy indication for code 111 |
| wr_en_i | input | 1 | Write strobe, one cycle |
| wr_sel_i | input | 1 | 0 = function register, 1 = control register |
| wr_data_i | input | 4 | Write data |
| interval_flag_o | output | 1 | Sticky period-elapsed flag |
| pin_n_o | output | 1 | Active-low pulse pin |

## Verification
A corrupted counter or segment index appears at the pin as a wrong interval length. This shows within the first period after a restart, or, for the 0.1 s pattern, within one group of five intervals. A sequencer stuck in the wrong state appears either as a missing pulse after a full period, or as a pulse after a stop or after a single-shot completion. A pulse register that fails to clear leaves the pin low past the next enable, which is visible one enable later. Flag faults show the first time a period elapses or a clear is written.

// File: rtl/ipt_pkg.sv
package ipt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HOLD = 2'd1,
        ST_RUN  = 2'd2,
        ST_DONE = 2'd3
    } ipt_state_t;

    localparam logic [2:0] PER_TENTH = 3'd0;
    localparam logic [2:0] PER_ONE   = 3'd1;
    localparam logic [2:0] PER_TEN   = 3'd2;
    localparam logic [2:0] PER_HALFM = 3'd3;
    localparam logic [2:0] PER_MIN   = 3'd4;
    localparam logic [2:0] SEL_BUSY  = 3'd7;
    localparam int         SEGS      = 5;
endpackage

// File: rtl/ipt_cfg.sv
module ipt_cfg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_sel,
    input  logic [3:0] wr_data,
    output logic [3:0] code_q,
    output logic       stop_q,
    output logic       dis_q,
    output logic       restart_q,
    output logic       fclr_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q    <= 4'd0;
            stop_q    <= 1'b1;
            dis_q     <= 1'b0;
            restart_q <= 1'b0;
            fclr_q    <= 1'b0;
        end else begin
            restart_q <= 1'b0;
            fclr_q    <= 1'b0;
            if (wr_en) begin
                if (!wr_sel) begin
                    code_q    <= wr_data;
                    restart_q <= 1'b1;
                end else begin
                    dis_q     <= wr_data[0];
                    restart_q <= wr_data[1];
                    stop_q    <= wr_data[2];
                    fclr_q    <= wr_data[3];
                end
            end
        end
    end
endmodule

// File: rtl/ipt_limit.sv
module ipt_limit #(
    parameter int HALF_SEC_TICKS = 16384,
    parameter int CW = 21
) (
    input  logic [2:0]    per,
    input  logic [2:0]    seg,
    output logic [CW-1:0] lim,
    output logic          valid
);
    import ipt_pkg::*;

    localparam int TBASE = HALF_SEC_TICKS / SEGS;
    localparam int TREM  = HALF_SEC_TICKS % SEGS;

    always_comb begin
        valid = 1'b1;
        lim   = CW'(1);
        unique case (per)
            PER_TENTH: lim = (int'(seg) < TREM) ? CW'(TBASE + 1) : CW'(TBASE);
            PER_ONE:   lim = CW'(2 * HALF_SEC_TICKS);
            PER_TEN:   lim = CW'(20 * HALF_SEC_TICKS);
            PER_HALFM: lim = CW'(60 * HALF_SEC_TICKS);
            PER_MIN:   lim = CW'(120 * HALF_SEC_TICKS);
            default: begin
                valid = 1'b0;
                lim   = CW'(1);
            end
        endcase
    end
endmodule

// File: rtl/ipt_fsm.sv
module ipt_fsm #(
    parameter int CW = 21
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                restart,
    input  logic                stop,
    input  logic                oneshot,
    input  logic                valid,
    input  logic                fclr,
    input  logic [CW-1:0]       lim,
    output ipt_pkg::ipt_state_t state,
    output logic [CW-1:0]       cnt,
    output logic [2:0]          seg,
    output logic                pulse,
    output logic                flag
);
    import ipt_pkg::*;

    ipt_state_t nxt;
    logic       fire;
    logic       advance;

    assign advance = (state == ST_RUN) && !stop && tick && !restart;
    assign fire    = advance && (cnt == (lim - CW'(1)));

    always_comb begin
        nxt = state;
        if (restart) begin
            nxt = !valid ? ST_IDLE : (stop ? ST_HOLD : ST_RUN);
        end else begin
            unique case (state)
                ST_IDLE: nxt = ST_IDLE;
                ST_HOLD: nxt = stop ? ST_HOLD : ST_RUN;
                ST_RUN: begin
                    if (stop)                  nxt = ST_HOLD;
                    else if (fire && oneshot)  nxt = ST_DONE;
                    else                       nxt = ST_RUN;
                end
                ST_DONE: nxt = ST_DONE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HOLD;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            seg   <= 3'd0;
            pulse <= 1'b0;
            flag  <= 1'b0;
        end else begin
            if (restart) begin
                cnt   <= '0;
                seg   <= 3'd0;
                pulse <= 1'b0;
            end else if (fire) begin
                cnt   <= '0;
                seg   <= (seg == 3'(SEGS - 1)) ? 3'd0 : seg + 3'd1;
                pulse <= 1'b1;
            end else begin
                if (advance) cnt <= cnt + CW'(1);
                if (tick)    pulse <= 1'b0;
            end
            if (fire)      flag <= 1'b1;
            else if (fclr) flag <= 1'b0;
        end
    end
endmodule

// File: rtl/interval_pulse_timer.sv
module interval_pulse_timer #(
    parameter int HALF_SEC_TICKS = 16384
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       busy_i,
    input  logic       wr_en_i,
    input  logic       wr_sel_i,
    input  logic [3:0] wr_data_i,
    output logic       interval_flag_o,
    output logic       pin_n_o
);
    import ipt_pkg::*;

    localparam int CW = $clog2(120 * HALF_SEC_TICKS + 1);

    logic [3:0]    code_q;
    logic          stop_q, dis_q, restart_q, fclr_q;
    logic [CW-1:0] lim;
    logic          valid;
    ipt_state_t    state;
    logic [CW-1:0] cnt;
    logic [2:0]    seg;
    logic          pulse, flag;
    logic          busy_mode, active;

    ipt_cfg u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .wr_sel(wr_sel_i),
        .wr_data(wr_data_i), .code_q(code_q), .stop_q(stop_q), .dis_q(dis_q),
        .restart_q(restart_q), .fclr_q(fclr_q)
    );

    ipt_limit #(.HALF_SEC_TICKS(HALF_SEC_TICKS), .CW(CW)) u_limit (
        .per(code_q[2:0]), .seg(seg), .lim(lim), .valid(valid)
    );

    ipt_fsm #(.CW(CW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick_i), .restart(restart_q),
        .stop(stop_q), .oneshot(code_q[3]), .valid(valid), .fclr(fclr_q),
        .lim(lim), .state(state), .cnt(cnt), .seg(seg), .pulse(pulse),
        .flag(flag)
    );

    assign busy_mode       = (code_q[2:0] == SEL_BUSY);
    assign active          = busy_mode ? busy_i : pulse;
    assign pin_n_o         = !(active && !dis_q);
    assign interval_flag_o = flag;
endmodule

// File: rtl/ipt_checker.sv
module ipt_checker #(
    parameter int CW = 21
) (
    input logic                clk,
    input logic                rst_n,
    input logic                tick,
    input logic                restart,
    input logic                dis,
    input ipt_pkg::ipt_state_t state,
    input logic [CW-1:0]       cnt,
    input logic [CW-1:0]       lim,
    input logic                pulse,
    input logic                flag,
    input logic                pin_n
);
    import ipt_pkg::*;

    // R5
    pulse_starts_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse) |-> $past(tick));

    // R5
    pulse_one_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse && tick && state != ST_RUN) |=> !pulse);

    // R7
    hold_keeps_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && !restart) |=> $stable(cnt));

    // R3
    count_below_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !restart) |-> (cnt < lim));

    // R9
    disabled_pin_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dis |-> pin_n);

    // R10
    flag_with_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $rose(pulse));

    // R6
    done_is_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE && !restart) |=> !$rose(pulse));
endmodule

bind interval_pulse_timer ipt_checker #(.CW(CW)) u_ipt_checker (
    .clk(clk), .rst_n(rst_n), .tick(tick_i), .restart(restart_q),
    .dis(dis_q), .state(state), .cnt(cnt), .lim(lim), .pulse(pulse),
    .flag(flag), .pin_n(pin_n_o)
);

// File: tb/test_interval_pulse_timer.sv
module test_interval_pulse_timer;
    localparam int H = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       busy_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic       wr_sel_i = 1'b0;
    logic [3:0] wr_data_i = 4'd0;
    logic       interval_flag_o;
    logic       pin_n_o;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    interval_pulse_timer #(.HALF_SEC_TICKS(H)) i_interval_pulse_timer (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .busy_i(busy_i),
        .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
        .interval_flag_o(interval_flag_o), .pin_n_o(pin_n_o)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_tick();
        @(negedge clk) tick_i = 1'b1;
        @(negedge clk) tick_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic sel, input logic [3:0] data);
        @(negedge clk) begin wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = data; end
        @(negedge clk) wr_en_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    // count enables until the pin goes low, starting from a given count
    task automatic measure(input int start, input int maxn, output int n);
        n = start;
        while (n < maxn) begin
            do_tick();
            n++;
            if (pin_n_o == 1'b0) break;
        end
    endtask

    // scan enables; returns the number of low pin observations
    task automatic count_lows(input int ticks, output int lows);
        lows = 0;
        for (int i = 0; i < ticks; i++) begin
            do_tick();
            if (pin_n_o == 1'b0) lows++;
        end
    endtask

    task automatic t_reset();
        int lows;
        check("R1 pin after reset", pin_n_o, 1);
        check("R1 flag after reset", interval_flag_o, 0);
        count_lows(40, lows);
        check("R1 stopped after reset", lows, 0);
    endtask

    task automatic t_tenth();
        int n;
        int sum;
        int exp_len[5] = '{3, 3, 2, 2, 2};
        wr(1'b1, 4'b0000);
        wr(1'b0, 4'b0000);
        sum = 0;
        measure(0, 50, n);
        check("R4 tenth seg0", n, exp_len[0]);
        sum += n;
        for (int s = 1; s < 5; s++) begin
            do_tick();
            check("R5 pin back high after one enable", pin_n_o, 1);
            measure(1, 50, n);
            check("R4 tenth segment", n, exp_len[s]);
            sum += n;
        end
        check("R4 five tenths sum to half second", sum, H);
        do_tick();
        measure(1, 50, n);
        check("R4 pattern restarts", n, exp_len[0]);
    endtask

    task automatic t_periods();
        int n;
        int exp_t[4] = '{2 * H, 20 * H, 60 * H, 120 * H};
        for (int c = 1; c <= 4; c++) begin
            wr(1'b1, 4'b1000);
            wr(1'b0, 4'(c));
            measure(0, 2000, n);
            check("R3 period length", n, exp_t[c-1]);
            check("R10 flag set on elapse", interval_flag_o, 1);
        end
        wr(1'b0, 4'b0001);
        measure(0, 200, n);
        do_tick();
        check("R5 pulse one enable wide", pin_n_o, 1);
        measure(1, 200, n);
        check("R6 repeat second period", n, 2 * H);
    endtask

    task automatic t_oneshot();
        int n;
        int lows;
        wr(1'b0, 4'b1001);
        measure(0, 200, n);
        check("R6 single-shot first pulse", n, 2 * H);
        do_tick();
        count_lows(5 * H, lows);
        check("R6 single-shot no further pulse", lows, 0);
    endtask

    task automatic t_stop();
        int n;
        int lows;
        wr(1'b0, 4'b0001);
        count_lows(10, lows);
        wr(1'b1, 4'b0100);
        count_lows(60, lows);
        check("R7 no pulse while stopped", lows, 0);
        wr(1'b1, 4'b0000);
        measure(0, 200, n);
        check("R7 resumed remainder", n, 2 * H - 10);
    endtask

    task automatic t_restart();
        int n;
        int lows;
        do_tick();
        count_lows(10, lows);
        wr(1'b1, 4'b0010);
        measure(0, 200, n);
        check("R8 counter reset restarts", n, 2 * H);
        do_tick();
        count_lows(10, lows);
        wr(1'b0, 4'b0001);
        measure(0, 200, n);
        check("R8 function write restarts", n, 2 * H);
    endtask

    task automatic t_disable_flag();
        int n;
        int lows;
        wr(1'b1, 4'b1001);
        check("R10 flag cleared", interval_flag_o, 0);
        measure(0, 3 * H, n);
        check("R9 pin held high when disabled", n, 3 * H);
        check("R9 flag still set when disabled", interval_flag_o, 1);
        wr(1'b1, 4'b1010);
        check("R10 flag cleared again", interval_flag_o, 0);
        count_lows(2 * H - 1, lows);
        check("R10 flag stays low before elapse", interval_flag_o, 0);
        do_tick();
        check("R10 flag set at elapse", interval_flag_o, 1);
        check("R9 pin low after re-enable", pin_n_o, 0);
    endtask

    task automatic t_reserved();
        int lows;
        wr(1'b0, 4'b0101);
        count_lows(6 * H, lows);
        check("R2 code 101 silent", lows, 0);
        wr(1'b0, 4'b0110);
        count_lows(6 * H, lows);
        check("R2 code 110 silent", lows, 0);
    endtask

    task automatic t_busy();
        wr(1'b0, 4'b0111);
        @(negedge clk) busy_i = 1'b1;
        @(negedge clk);
        check("R11 busy high drives pin low", pin_n_o, 0);
        @(negedge clk) busy_i = 1'b0;
        @(negedge clk);
        check("R11 busy low releases pin", pin_n_o, 1);
        wr(1'b1, 4'b0001);
        @(negedge clk) busy_i = 1'b1;
        @(negedge clk);
        check("R11 busy masked by disable", pin_n_o, 1);
        @(negedge clk) busy_i = 1'b0;
        wr(1'b1, 4'b0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_tenth();
        t_periods();
        t_oneshot();
        t_stop();
        t_restart();
        t_disable_flag();
        t_reserved();
        t_busy();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule